// File: doc/BRIEF.md
# Multi-Bank Program Store Switcher

This block supplies a small soft processor with its instruction words from one of several independent instruction RAM banks. A multiplexer picks the active bank, and the processor fetches through a single read port: it presents an address and receives the stored word one clock later. Code can be rewritten bank by bank through a separate write port. A bank that is not currently active can be loaded while the processor keeps running from the active one.

To change programs, a swap request names a target bank. The block then asserts the processor reset, moves the bank select while reset is held, and releases reset. The processor therefore starts again at address 0 of the new code. The sequence always takes the same two cycles, whatever the bank depth. While it runs, a busy flag is high and any further swap request is dropped. A write aimed at the bank the processor is executing from is refused and reported with a one-cycle error pulse. The trigger can come from any event source, such as an interrupt line.

Top module: `program_store_switcher`

## Requirements
- R1: A swap request sampled while the block is idle raises `cpu_rst` from the next clock edge.
- R2: `cpu_rst` stays high for exactly two cycles per swap, independent of bank depth, and `busy` is high in exactly the same cycles.
- R3: `active_bank` changes only while `cpu_rst` is high. It takes the requested bank at the second clock edge after the request, so reset is high both before and after the change.
- R4: A swap request naming the bank that is already active still performs the full two-cycle reset sequence.
- R5: A swap request arriving while `busy` is high is ignored. It neither changes the bank chosen by the running swap nor starts a further reset.
- R6: `instr` equals the word stored at `fetch_addr` in the active bank, one cycle after the address is presented.
- R7: A write (`wr_en` high) to a bank other than the active one stores `wr_data` at `wr_addr` of that bank, whether or not the processor is running. It raises no error.
- R8: A write whose `wr_bank` equals `active_bank` leaves every bank unchanged. It raises `wr_err` for exactly one cycle, in the cycle after the write.
- R9: After reset, `active_bank` is 0 and `cpu_rst`, `busy` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_req | input | 1 | Request to switch the active bank |
| swap_bank | input | BSEL_W | Target bank of the swap request |
| wr_en | input | 1 | Write strobe for code loading |
| wr_bank | input | BSEL_W | Bank addressed by the write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | WORD_W | Instruction word to store |
| fetch_addr | input | ADDR_W | Processor fetch address |
| instr | output | WORD_W | Instruction word from the active bank |
| cpu_rst | output | 1 | Reset to the processor, high during a swap |
| busy | output | 1 | Swap sequence in progress |
| active_bank | output | BSEL_W | Bank currently feeding the processor |
| wr_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest case to reach is a second swap request that lands inside the two-cycle window of a running swap. It must be dropped without disturbing the bank chosen by the first request. The bench drives the second request, naming a different bank, in the very cycle after the first one starts. It then confirms that the first target is selected and that `cpu_rst` stays low afterwards. A refused write is likewise aimed at an address whose correct content is known. That address is then read back in a full sweep of the bank, so a write that leaked through would show up.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    SW_IDLE   = 2'd0,
    SW_ENTER  = 2'd1,
    SW_SETTLE = 2'd2
  } sw_state_t;

  // a bank index names an existing bank
  function automatic logic bank_exists(input int unsigned idx, input int unsigned nbanks);
    return idx < nbanks;
  endfunction

  // one-hot write-enable decode, with the active bank masked out
  function automatic logic [63:0] write_decode(input int unsigned wbank,
                                               input int unsigned abank,
                                               input logic        wen,
                                               input int unsigned nbanks);
    logic [63:0] v;
    v = '0;
    if (wen && wbank != abank && wbank < nbanks && wbank < 64)
      v[wbank] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/pss_swap_seq.sv
module pss_swap_seq
  import pss_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_req,
  input  logic [BSEL_W-1:0] swap_bank,
  output logic              cpu_rst,
  output logic              busy,
  output logic [BSEL_W-1:0] active_bank
);

  sw_state_t         state_q;
  logic [BSEL_W-1:0] target_q;
  logic [BSEL_W-1:0] active_q;

  // named internal events
  logic swap_start;
  logic sel_load;

  assign swap_start = (state_q == SW_IDLE) && swap_req &&
                      bank_exists(int'(swap_bank), NUM_BANKS);
  assign sel_load   = (state_q == SW_ENTER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SW_IDLE;
      target_q <= '0;
      active_q <= '0;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (swap_start) begin
            target_q <= swap_bank;
            state_q  <= SW_ENTER;
          end
        end
        SW_ENTER: begin
          active_q <= target_q;
          state_q  <= SW_SETTLE;
        end
        SW_SETTLE: state_q <= SW_IDLE;
        default:   state_q <= SW_IDLE;
      endcase
    end
  end

  assign cpu_rst     = (state_q != SW_IDLE);
  assign busy        = (state_q == SW_ENTER) || (state_q == SW_SETTLE);
  assign active_bank = active_q;

  AST_START_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    swap_start |=> cpu_rst); // R1
  AST_RST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |=> cpu_rst); // R2
  AST_RST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst && $past(cpu_rst)) |=> !cpu_rst); // R2
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy == cpu_rst); // R2
  AST_SEL_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (active_bank != $past(active_bank)) |-> (cpu_rst && $past(cpu_rst))); // R3
  AST_SEL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    swap_start |=> ##1 (active_bank == $past(swap_bank, 2))); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && swap_req && !sel_load) |=> !cpu_rst); // R5

endmodule

// File: rtl/pss_bank_array.sv
module pss_bank_array
  import pss_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 2,
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BSEL_W-1:0] active_bank,
  input  logic              wr_en,
  input  logic [BSEL_W-1:0] wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              wr_err
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [NUM_BANKS-1:0]             bank_we;
  logic [NUM_BANKS-1:0][WORD_W-1:0] rd_all;
  logic                             wr_hits_active;
  logic                             wr_err_q;
  logic [63:0]                      we_wide;

  assign we_wide        = write_decode(int'(wr_bank), int'(active_bank), wr_en, NUM_BANKS);
  assign bank_we        = we_wide[NUM_BANKS-1:0];
  assign wr_hits_active = wr_en && (wr_bank == active_bank);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (bank_we[g]) mem[wr_addr] <= wr_data;
      q <= mem[rd_addr];
    end
    assign rd_all[g] = q;
  end

  assign rd_data = rd_all[active_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err_q <= 1'b0;
    else        wr_err_q <= wr_hits_active;
  end
  assign wr_err = wr_err_q;

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we)); // R7
  AST_NO_ACTIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hits_active |-> (bank_we == '0)); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hits_active |=> wr_err); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en)); // R8

endmodule

// File: rtl/program_store_switcher.sv
module program_store_switcher #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 18,
  parameter int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_req,
  input  logic [BSEL_W-1:0] swap_bank,
  input  logic              wr_en,
  input  logic [BSEL_W-1:0] wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] instr,
  output logic              cpu_rst,
  output logic              busy,
  output logic [BSEL_W-1:0] active_bank,
  output logic              wr_err
);

  logic [BSEL_W-1:0] sel;

  pss_swap_seq #(
    .NUM_BANKS (NUM_BANKS),
    .BSEL_W    (BSEL_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .swap_req    (swap_req),
    .swap_bank   (swap_bank),
    .cpu_rst     (cpu_rst),
    .busy        (busy),
    .active_bank (sel)
  );

  pss_bank_array #(
    .NUM_BANKS (NUM_BANKS),
    .BSEL_W    (BSEL_W),
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W)
  ) u_banks (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_bank (sel),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (fetch_addr),
    .rd_data     (instr),
    .wr_err      (wr_err)
  );

  assign active_bank = sel;

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (!cpu_rst && !wr_err && active_bank == '0)); // R9

endmodule

// File: tb/tb_program_store_switcher.sv
module tb_program_store_switcher;

  localparam int NB = 4;
  localparam int AW = 8;
  localparam int WW = 18;
  localparam int BW = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          swap_req = 1'b0;
  logic [BW-1:0] swap_bank = '0;
  logic          wr_en = 1'b0;
  logic [BW-1:0] wr_bank = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [AW-1:0] fetch_addr = '0;
  logic [WW-1:0] instr;
  logic          cpu_rst;
  logic          busy;
  logic [BW-1:0] active_bank;
  logic          wr_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  program_store_switcher #(.NUM_BANKS(NB), .ADDR_W(AW), .WORD_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .swap_bank(swap_bank),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .fetch_addr(fetch_addr), .instr(instr), .cpu_rst(cpu_rst), .busy(busy),
    .active_bank(active_bank), .wr_err(wr_err)
  );

  function automatic logic [WW-1:0] pat(input int b, input int a);
    int v;
    v = (b * 20011 + a * 389 + 7) ^ (a << 5);
    return WW'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic write_word(input int b, input int a, input logic [WW-1:0] d, input bit expect_err);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = BW'(b); wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(wr_err == expect_err, expect_err ? "R8 err pulse" : "R7 no err", int'(wr_err), int'(expect_err));
    if (expect_err) begin
      @(negedge clk);
      check(wr_err == 1'b0, "R8 err one cycle", int'(wr_err), 0);
    end
  endtask

  task automatic fill_bank(input int b);
    for (int a = 0; a < DEPTH; a++) write_word(b, a, pat(b, a), 1'b0);
  endtask

  task automatic sweep_bank(input int b);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      fetch_addr = AW'(a);
      @(negedge clk);
      check(instr == pat(b, a), "R6 fetch word", int'(instr), int'(pat(b, a)));
    end
  endtask

  // swap with full timing checks; returns after reset released
  task automatic do_swap(input int tgt, input string req);
    int old;
    old = int'(active_bank);
    @(negedge clk);
    swap_req = 1'b1; swap_bank = BW'(tgt);
    @(negedge clk);
    swap_req = 1'b0;
    check(cpu_rst == 1'b1, {req, " R1 reset rises"}, int'(cpu_rst), 1);
    check(busy == 1'b1, {req, " R2 busy"}, int'(busy), 1);
    check(int'(active_bank) == old, {req, " R3 no early change"}, int'(active_bank), old);
    @(negedge clk);
    check(cpu_rst == 1'b1, {req, " R2 second reset cycle"}, int'(cpu_rst), 1);
    check(int'(active_bank) == tgt, {req, " R3 bank changes"}, int'(active_bank), tgt);
    @(negedge clk);
    check(cpu_rst == 1'b0, {req, " R2 reset released"}, int'(cpu_rst), 0);
    check(busy == 1'b0, {req, " R2 busy low"}, int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(active_bank == '0, "R9 bank 0", int'(active_bank), 0);
    check(cpu_rst == 1'b0, "R9 cpu_rst low", int'(cpu_rst), 0);
    check(busy == 1'b0, "R9 busy low", int'(busy), 0);
    check(wr_err == 1'b0, "R9 wr_err low", int'(wr_err), 0);

    for (int b = 1; b < NB; b++) fill_bank(b);   // R7 inactive banks
    do_swap(1, "swap1");
    fill_bank(0);                                // R7 while running from bank 1
    write_word(1, 5, ~pat(1, 5), 1'b1);          // R8 refused
    sweep_bank(1);                               // R6, R8 content unchanged
    do_swap(1, "R4 same bank");
    check(active_bank == 2'd1, "R4 bank kept", int'(active_bank), 1);

    // R5: second request during busy
    @(negedge clk);
    swap_req = 1'b1; swap_bank = 2'd2;
    @(negedge clk);
    swap_bank = 2'd3;                            // busy now; request held high
    @(negedge clk);
    swap_req = 1'b0;
    check(active_bank == 2'd2, "R5 first target wins", int'(active_bank), 2);
    @(negedge clk);
    check(cpu_rst == 1'b0, "R5 reset released", int'(cpu_rst), 0);
    @(negedge clk);
    check(cpu_rst == 1'b0, "R5 no extra swap", int'(cpu_rst), 0);
    check(active_bank == 2'd2, "R5 bank stays", int'(active_bank), 2);
    sweep_bank(2);

    do_swap(0, "swap0");
    sweep_bank(0);
    do_swap(3, "swap3");
    sweep_bank(3);
    write_word(3, 0, 18'h0, 1'b1);               // R8 on another bank
    @(negedge clk);
    fetch_addr = '0;
    @(negedge clk);
    check(instr == pat(3, 0), "R8 active word intact", int'(instr), int'(pat(3, 0)));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule